// File: doc/BRIEF.md
# Dual Prescaled Blink PWM Generator

This block produces two independent LED blink waveforms for an LED driver. Each channel takes an 8-bit period setting and an 8-bit brightness (duty) setting from a register file elsewhere in the chip. It drives an active-low blink signal that an output selector can route to any LED pad. The period of a channel is (period setting + 1)/152 seconds. Each period is split into 256 equal steps, and the LED is lit for as many steps as the duty setting names.

A shared base tick is derived from the system clock by an integer divider, sized from the `CLK_HZ` parameter so that it runs at 152 × 256 Hz. A second parameter, `TICK_SCALE`, speeds the tick up by a fixed factor so that a short simulation can cover whole periods. Each channel counts base ticks in a prescaler and advances its 8-bit step counter on prescaler wrap. New settings are adopted only when a period ends, so a waveform is never cut short or glitched.

Top module: `dual_blink_pwm`

## Requirements
- R1: The base tick repeats every D system clocks, with D = max(1, CLK_HZ / (38912 × TICK_SCALE)). One channel period lasts 256 × (period setting + 1) base ticks, which is 256 × (psc + 1) × D clocks.
- R2: The output of each channel is low at the start of each period for duty × (psc + 1) × D clocks, and high for the rest of the period.
- R3: The output is active low. It is 0 (LED lit) while the channel's 8-bit step count is below the active duty value, and 1 otherwise.
- R4: A duty value of 00h holds the output at 1 for the whole period, every period.
- R5: After reset the active duty is 80h, the active period setting is 00h and the step count is 0. Both outputs therefore read 0 right after reset, and the first period is 256 × D clocks long with 128 × D clocks low.
- R6: A change to a channel's period or duty input takes effect only when the step count wraps from FFh to 00h. The rest of the current period keeps the old values.
- R7: The two channels share no state and can run with different period and duty settings at the same time.
- R8: A duty value of FFh leaves the output high for exactly (psc + 1) × D clocks at the end of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc0_i | input | 8 | Period setting, channel 0 |
| duty0_i | input | 8 | Duty setting, channel 0 |
| psc1_i | input | 8 | Period setting, channel 1 |
| duty1_i | input | 8 | Duty setting, channel 1 |
| blink0_n | output | 1 | Active-low blink output, channel 0 |
| blink1_n | output | 1 | Active-low blink output, channel 1 |

## Verification
The assertions check the following on every cycle:
- a zero duty keeps the output high;
- step counters move only on a step tick;
- step ticks occur only on base ticks;
- active settings change only at the FFh-to-00h wrap.

Other behaviour depends on absolute clock counts, so only the bench scenarios can show it:
- the exact period and low-time lengths;
- the reset waveform;
- the deferred adoption of a setting changed part-way through a period;
- two channels running together at different rates.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam int unsigned STEP_HZ  = 152 * 256;
  localparam logic [7:0]  DUTY_RST = 8'h80;
  localparam logic [7:0]  PSC_RST  = 8'h00;

  // Clocks per base tick, never below one.
  function automatic int unsigned base_div(input int unsigned clk_hz,
                                           input int unsigned scale);
    int unsigned d;
    d = clk_hz / (STEP_HZ * scale);
    return (d == 0) ? 1 : d;
  endfunction

  // Output level for a given step and duty: 0 = lit.
  function automatic logic level_n(input logic [7:0] step,
                                   input logic [7:0] duty);
    return !(step < duty);
  endfunction
endpackage

// File: rtl/blink_tick_gen.sv
module blink_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/blink_chan.sv
module blink_chan
  import blink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick_i,
  input  logic [7:0] psc_i,
  input  logic [7:0] duty_i,
  output logic       blink_n_o,
  output logic [7:0] step_o,
  output logic       step_tick_o,
  output logic       wrap_o,
  output logic [7:0] duty_act_o,
  output logic [7:0] psc_act_o
);
  logic [7:0] pcnt_q, step_q, duty_q, psc_q;
  logic       step_tick, wrap;

  assign step_tick = base_tick_i && (pcnt_q == psc_q);
  assign wrap      = step_tick && (step_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      step_q <= '0;
      duty_q <= DUTY_RST;
      psc_q  <= PSC_RST;
    end else begin
      if (step_tick)        pcnt_q <= '0;
      else if (base_tick_i) pcnt_q <= pcnt_q + 1'b1;
      if (step_tick)        step_q <= step_q + 1'b1;
      if (wrap) begin
        duty_q <= duty_i;
        psc_q  <= psc_i;
      end
    end
  end

  assign blink_n_o   = level_n(step_q, duty_q);
  assign step_o      = step_q;
  assign step_tick_o = step_tick;
  assign wrap_o      = wrap;
  assign duty_act_o  = duty_q;
  assign psc_act_o   = psc_q;
endmodule

// File: rtl/dual_blink_pwm.sv
module dual_blink_pwm
  import blink_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 10_000_000,
  parameter int unsigned TICK_SCALE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] psc0_i,
  input  logic [7:0] duty0_i,
  input  logic [7:0] psc1_i,
  input  logic [7:0] duty1_i,
  output logic       blink0_n,
  output logic       blink1_n
);
  localparam int unsigned DIV = base_div(CLK_HZ, TICK_SCALE);
  localparam int          NCH = 2;

  logic                      base_tick;
  logic [NCH-1:0][7:0]       psc_in, duty_in, step, duty_act, psc_act;
  logic [NCH-1:0]            step_tick, wrap, blink_n;

  assign psc_in  = {psc1_i, psc0_i};
  assign duty_in = {duty1_i, duty0_i};

  blink_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(base_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    blink_chan u_ch (
      .clk(clk), .rst_n(rst_n), .base_tick_i(base_tick),
      .psc_i(psc_in[c]), .duty_i(duty_in[c]),
      .blink_n_o(blink_n[c]), .step_o(step[c]),
      .step_tick_o(step_tick[c]), .wrap_o(wrap[c]),
      .duty_act_o(duty_act[c]), .psc_act_o(psc_act[c])
    );
  end

  assign blink0_n = blink_n[0];
  assign blink1_n = blink_n[1];
endmodule

// File: rtl/dual_blink_pwm_chk.sv
module dual_blink_pwm_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            base_tick,
  input logic [1:0]      step_tick,
  input logic [1:0]      wrap,
  input logic [1:0][7:0] step,
  input logic [1:0][7:0] duty_act,
  input logic [1:0][7:0] psc_act,
  input logic            blink0_n,
  input logic            blink1_n
);
  logic [1:0] outs;
  assign outs = {blink1_n, blink0_n};

  for (genvar c = 0; c < 2; c++) begin : g_c
    p_zero_duty_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act[c] == 8'h00) |-> outs[c]);
    p_step_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !step_tick[c] |=> $stable(step[c]));
    p_step_on_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step_tick[c] |-> base_tick);
    p_latch_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap[c] |=> ($stable(duty_act[c]) && $stable(psc_act[c])));
    p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[c] |=> (step[c] == 8'h00));
  end
endmodule

bind dual_blink_pwm dual_blink_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
  .step_tick(step_tick), .wrap(wrap), .step(step),
  .duty_act(duty_act), .psc_act(psc_act),
  .blink0_n(blink0_n), .blink1_n(blink1_n)
);

// File: tb/sim_dual_blink_pwm.sv
`timescale 1ns/1ps
module sim_dual_blink_pwm;
  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int unsigned SCALE  = 642;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] psc0 = 8'h00, duty0 = 8'h80, psc1 = 8'h00, duty1 = 8'h80;
  logic b0, b1;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_blink_pwm #(.CLK_HZ(CLK_HZ), .TICK_SCALE(SCALE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .psc0_i(psc0), .duty0_i(duty0), .psc1_i(psc1), .duty1_i(duty1),
    .blink0_n(b0), .blink1_n(b1)
  );

  function automatic int exp_d();
    int d;
    d = CLK_HZ / (152 * 256 * SCALE);
    return (d < 1) ? 1 : d;
  endfunction
  function automatic int exp_per(input int psc);
    return 256 * (psc + 1) * exp_d();
  endfunction
  function automatic int exp_low(input int duty, input int psc);
    return duty * (psc + 1) * exp_d();
  endfunction
  function automatic logic outv(input int ch);
    return (ch == 0) ? b0 : b1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(input int ch);
    logic prev;
    prev = outv(ch);
    forever begin
      @(negedge clk);
      if (prev && !outv(ch)) break;
      prev = outv(ch);
    end
  endtask

  // Called at the first low sample of a period.
  task automatic count_period(input int ch, output int lowc, output int per);
    lowc = 1;
    per = 1;
    forever begin
      @(negedge clk);
      if (outv(ch)) break;
      lowc++; per++;
    end
    forever begin
      per++;
      @(negedge clk);
      if (!outv(ch)) break;
    end
  endtask

  task automatic measure(input int ch, input string req, input int duty, input int psc);
    int lc, pc;
    wait_fall(ch);
    count_period(ch, lc, pc);
    check({req, " low"}, lc, exp_low(duty, psc));
    check({req, " period"}, pc, exp_per(psc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lc, pc;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R5 reset out0", int'(b0), 0);
    check("R5 reset out1", int'(b1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: first period from reset, starting at step 0
    lc = 1; pc = 0;
    forever begin
      @(negedge clk);
      if (b0) break;
      lc++;
    end
    check("R5 first low", lc, exp_low(128, 0) - 1);
    measure(0, "R5 default", 128, 0);

    // R2/R3: directed duty values
    psc0 = 8'd1; duty0 = 8'h40;
    measure(0, "R2 duty40", 64, 1);
    // R8: full-scale duty
    psc0 = 8'd0; duty0 = 8'hFF;
    measure(0, "R8 dutyFF", 255, 0);
    // R3: smallest nonzero duty
    duty0 = 8'h01; psc0 = 8'd2;
    measure(0, "R3 duty01", 1, 2);

    // R6: mid-period change is deferred
    psc0 = 8'd1; duty0 = 8'h40;
    measure(0, "R6 setup", 64, 1);
    wait_fall(0);
    repeat (10) @(negedge clk);
    duty0 = 8'h10; psc0 = 8'd0;
    lc = 11;
    forever begin
      @(negedge clk);
      if (b0) break;
      lc++;
    end
    check("R6 old duty kept", lc, exp_low(64, 1));
    measure(0, "R6 new value", 16, 0);

    // R4: zero duty never lights
    psc1 = 8'd1; duty1 = 8'h00;
    repeat (exp_per(0) + exp_per(1) + 4) @(negedge clk);
    lc = 0;
    for (int i = 0; i < 2 * exp_per(1); i++) begin
      @(negedge clk);
      if (!b1) lc++;
    end
    check("R4 zero duty low cycles", lc, 0);

    // R7: channels with different settings at once
    psc0 = 8'd0; duty0 = 8'h20; psc1 = 8'd2; duty1 = 8'hC0;
    measure(0, "R7 ch0", 32, 0);
    measure(1, "R7 ch1", 192, 2);

    // R1/R2: random settings
    for (int k = 0; k < 6; k++) begin
      int ch, p, d;
      ch = k % 2;
      p = $urandom_range(0, 2);
      d = $urandom_range(1, 255);
      if (ch == 0) begin psc0 = 8'(p); duty0 = 8'(d); end
      else         begin psc1 = 8'(p); duty1 = 8'(d); end
      measure(ch, "R1 random", d, p);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule